// File: doc/BRIEF.md
# Vectored Interrupt Priority Core

This block is the interrupt acceptance core that sits beside one processor. It keeps three 256-entry bit vectors indexed by an 8-bit vector number: pending requests, vectors in service, and the trigger mode (level or edge) that was recorded with each request. It also holds a task priority value and a 9-bit spurious/enable word. Upstream routing logic drops requests in through a set port. The core raises `irq_out` whenever the best pending request outranks the current processor priority.

The processor answers with an acknowledge handshake. One cycle after `ack_req`, the core reports one of three outcomes: the vector it granted, the spurious vector, or nothing. A granted vector moves from pending to in service. An end-of-interrupt strobe retires the highest vector in service. Priority is ranked in classes of 16 vectors, taken from the upper nibble of the vector number. The processor priority is the larger of the task priority and the class of the highest vector in service, and it is available on `proc_pri`.

The acknowledge sequencer is a two-state machine. `ST_IDLE` means no reply is due. `ST_REPLY` means a reply is on the acknowledge outputs this cycle. The transitions are:
- `ST_IDLE` to `ST_REPLY` when `ack_req` is high.
- `ST_IDLE` to `ST_IDLE` otherwise.
- `ST_REPLY` to `ST_REPLY` when `ack_req` is high again, which gives back-to-back acknowledges.
- `ST_REPLY` to `ST_IDLE` otherwise.

Top module: `vic_core`

## Requirements
- R1: While reset is held and right after it, `irq_out` is 0, `proc_pri` is 0 and `ack_valid` is 0. The spurious/enable word resets to 0x0FF, so bit 8 (enable) is clear. The task priority and all three bit vectors reset to zero.
- R2: A set event marks `set_vector` pending and records its trigger mode: 1 for level, 0 for edge. A later set of the same vector overwrites the mode. A granted acknowledge returns the recorded mode on `ack_level`.
- R3: Let C be the class (bits 7:4) of the highest in-service vector, or 0 if none is in service. `proc_pri` equals the task priority when its bits 7:4 are at least C. Otherwise it equals C shifted left by 4.
- R4: `irq_out` is 1 only when three conditions hold: enable bit 8 is set, a request is pending, and either `proc_pri` is 0 or the class of the highest pending vector is strictly greater than bits 7:4 of `proc_pri`.
- R5: The higher vector number has the higher priority. A granted acknowledge returns the highest pending vector with `ack_kind` = 2'b01. It clears that vector's pending bit and sets its in-service bit.
- R6: Suppose the core is enabled, a request is pending, the task priority is nonzero, and the highest pending vector is less than or equal to the full 8-bit task priority. Then the acknowledge returns `ack_kind` = 2'b10 with the low 8 bits of the spurious word, and the pending and in-service state stay unchanged.
- R7: An acknowledge while enable is clear, or while nothing is pending, returns `ack_kind` = 2'b00 and changes no state.
- R8: End-of-interrupt clears only the highest set in-service bit. With no bit in service it has no effect.
- R9: A set event and an acknowledge that land on the same vector in one cycle are handled in order: the acknowledge takes the vector first, and the set then leaves it pending again.
- R10: `ack_valid` is high for exactly the cycle after each cycle with `ack_req` high, and low in every other cycle. `ack_kind` never takes the value 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_valid | input | 1 | Request event strobe |
| set_vector | input | 8 | Vector being requested |
| set_level | input | 1 | Trigger mode of the request (1 level, 0 edge) |
| tpr_wr | input | 1 | Task priority write strobe |
| tpr_data | input | 8 | New task priority |
| spur_wr | input | 1 | Spurious/enable word write strobe |
| spur_data | input | 9 | New word: bit 8 enable, bits 7:0 spurious vector |
| ack_req | input | 1 | Acknowledge request from the processor |
| eoi_strobe | input | 1 | End-of-interrupt strobe |
| irq_out | output | 1 | Interrupt line to the processor |
| proc_pri | output | 8 | Current processor priority |
| ack_valid | output | 1 | Acknowledge reply present |
| ack_kind | output | 2 | 01 vector, 10 spurious, 00 none |
| ack_vector | output | 8 | Returned vector |
| ack_level | output | 1 | Trigger mode of a granted vector |

## Verification
The assertions check the following on every cycle:
- the reply timing of the acknowledge handshake and its legal kinds;
- that `irq_out` never rises while the core is disabled or has nothing pending;
- that `proc_pri` never falls below the task priority;
- that a granted vector is in service while its reply is shown;
- that a spurious reply carries the spurious vector;
- that end-of-interrupt retires exactly one in-service bit.

Only the bench scenarios can show which vector wins and the exact priority values that nested service produces. The same holds for these cases:
- a blocked request that survives a spurious reply;
- the difference between the class test on the line and the full 8-bit test on acknowledge;
- a set that collides with an acknowledge on the same vector;
- the vector-0 and vector-255 boundaries.

// File: rtl/vic_pkg.sv
package vic_pkg;
    typedef enum logic [1:0] {
        ACK_NONE = 2'b00,
        ACK_VEC  = 2'b01,
        ACK_SPUR = 2'b10
    } ack_kind_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_REPLY = 1'b1
    } ack_state_e;
endpackage

// File: rtl/vic_top_find.sv
// Highest-set-bit finder, split into groups to shorten the priority chain.
module vic_top_find #(
    parameter int WIDTH = 256,
    parameter int GRP   = 16,
    localparam int IW   = $clog2(WIDTH),
    localparam int NGRP = WIDTH / GRP,
    localparam int GW   = $clog2(GRP),
    localparam int NW   = (NGRP > 1) ? $clog2(NGRP) : 1
) (
    input  logic [WIDTH-1:0] bits,
    output logic             any,
    output logic [IW-1:0]    idx
);
    logic [NGRP-1:0]         grp_any;
    logic [NGRP-1:0][GW-1:0] grp_idx;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        logic [GRP-1:0] slice;
        logic           loc_any;
        logic [GW-1:0]  loc_idx;
        assign slice = bits[g*GRP +: GRP];
        always_comb begin
            loc_any = 1'b0;
            loc_idx = '0;
            for (int b = 0; b < GRP; b++) begin
                if (slice[b]) begin
                    loc_any = 1'b1;
                    loc_idx = GW'(b);
                end
            end
        end
        assign grp_any[g] = loc_any;
        assign grp_idx[g] = loc_idx;
    end

    logic [NW-1:0] sel;
    always_comb begin
        sel = '0;
        for (int g = 0; g < NGRP; g++) begin
            if (grp_any[g]) sel = NW'(g);
        end
    end

    assign any = |grp_any;
    assign idx = IW'({sel, grp_idx[sel]});
endmodule

// File: rtl/vic_vec_store.sv
// Pending / in-service / trigger-mode vectors.
module vic_vec_store #(
    parameter int NUM_VEC = 256,
    localparam int VW     = $clog2(NUM_VEC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_valid,
    input  logic [VW-1:0]      set_vector,
    input  logic               set_level,
    input  logic               take,
    input  logic [VW-1:0]      take_vec,
    input  logic               drop,
    input  logic [VW-1:0]      drop_vec,
    output logic [NUM_VEC-1:0] irr_vec,
    output logic [NUM_VEC-1:0] isr_vec,
    output logic [NUM_VEC-1:0] tmr_vec
);
    logic [NUM_VEC-1:0] irr_d, isr_d, tmr_d;

    always_comb begin
        irr_d = irr_vec;
        isr_d = isr_vec;
        tmr_d = tmr_vec;
        // retire first, then grant, then the new request (R9 ordering)
        if (drop) isr_d[drop_vec] = 1'b0;
        if (take) begin
            irr_d[take_vec] = 1'b0;
            isr_d[take_vec] = 1'b1;
        end
        if (set_valid) begin
            irr_d[set_vector] = 1'b1;
            tmr_d[set_vector] = set_level;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irr_vec <= '0;
            isr_vec <= '0;
            tmr_vec <= '0;
        end else begin
            irr_vec <= irr_d;
            isr_vec <= isr_d;
            tmr_vec <= tmr_d;
        end
    end
endmodule

// File: rtl/vic_ack_fsm.sv
// Acknowledge sequencer: decides in the request cycle, replies in the next.
module vic_ack_fsm
    import vic_pkg::*;
#(
    parameter int VW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ack_req,
    input  logic          enable,
    input  logic          pend_any,
    input  logic [VW-1:0] pend_top,
    input  logic          pend_level,
    input  logic [VW-1:0] tpr,
    input  logic [VW-1:0] spur_vec,
    output logic          take,
    output logic          ack_valid,
    output logic [1:0]    ack_kind,
    output logic [VW-1:0] ack_vector,
    output logic          ack_level
);
    ack_state_e state_q, state_d;
    ack_kind_e  kind_d, kind_q;
    logic [VW-1:0] vec_d, vec_q;
    logic          lvl_d, lvl_q;
    logic          blocked;

    assign blocked = (tpr != '0) && (pend_top <= tpr);

    always_comb begin
        kind_d = ACK_NONE;
        vec_d  = '0;
        lvl_d  = 1'b0;
        if (enable && pend_any) begin
            if (blocked) begin
                kind_d = ACK_SPUR;
                vec_d  = spur_vec;
            end else begin
                kind_d = ACK_VEC;
                vec_d  = pend_top;
                lvl_d  = pend_level;
            end
        end
    end

    assign take = ack_req && (kind_d == ACK_VEC);

    always_comb begin
        unique case (state_q)
            ST_IDLE:  state_d = ack_req ? ST_REPLY : ST_IDLE;
            ST_REPLY: state_d = ack_req ? ST_REPLY : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            kind_q  <= ACK_NONE;
            vec_q   <= '0;
            lvl_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (ack_req) begin
                kind_q <= kind_d;
                vec_q  <= vec_d;
                lvl_q  <= lvl_d;
            end
        end
    end

    always_comb begin
        ack_valid  = 1'b0;
        ack_kind   = ACK_NONE;
        ack_vector = '0;
        ack_level  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_REPLY: begin
                ack_valid  = 1'b1;
                ack_kind   = kind_q;
                ack_vector = vec_q;
                ack_level  = lvl_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/vic_core.sv
module vic_core #(
    parameter int NUM_VEC = 256,
    parameter int GRP     = 16,
    localparam int VW     = $clog2(NUM_VEC),
    localparam int CW     = VW - 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_valid,
    input  logic [VW-1:0] set_vector,
    input  logic          set_level,
    input  logic          tpr_wr,
    input  logic [VW-1:0] tpr_data,
    input  logic          spur_wr,
    input  logic [VW:0]   spur_data,
    input  logic          ack_req,
    input  logic          eoi_strobe,
    output logic          irq_out,
    output logic [VW-1:0] proc_pri,
    output logic          ack_valid,
    output logic [1:0]    ack_kind,
    output logic [VW-1:0] ack_vector,
    output logic          ack_level
);
    logic [VW-1:0]      tpr_q;
    logic [VW:0]        spur_q;
    logic [NUM_VEC-1:0] irr_vec, isr_vec, tmr_vec;
    logic               irr_any, isr_any, take;
    logic [VW-1:0]      irr_top, isr_top;
    logic [CW-1:0]      isr_cls;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tpr_q  <= '0;
            spur_q <= (VW+1)'({VW{1'b1}});
        end else begin
            if (tpr_wr)  tpr_q  <= tpr_data;
            if (spur_wr) spur_q <= spur_data;
        end
    end

    vic_vec_store #(.NUM_VEC(NUM_VEC)) u_store (
        .clk(clk), .rst_n(rst_n),
        .set_valid(set_valid), .set_vector(set_vector), .set_level(set_level),
        .take(take), .take_vec(irr_top),
        .drop(eoi_strobe && isr_any), .drop_vec(isr_top),
        .irr_vec(irr_vec), .isr_vec(isr_vec), .tmr_vec(tmr_vec)
    );

    vic_top_find #(.WIDTH(NUM_VEC), .GRP(GRP)) u_find_irr (
        .bits(irr_vec), .any(irr_any), .idx(irr_top)
    );

    vic_top_find #(.WIDTH(NUM_VEC), .GRP(GRP)) u_find_isr (
        .bits(isr_vec), .any(isr_any), .idx(isr_top)
    );

    assign isr_cls  = isr_any ? isr_top[VW-1:4] : '0;
    assign proc_pri = (tpr_q[VW-1:4] >= isr_cls) ? tpr_q : {isr_cls, 4'h0};
    assign irq_out  = spur_q[VW] && irr_any &&
                      ((proc_pri == '0) || (irr_top[VW-1:4] > proc_pri[VW-1:4]));

    vic_ack_fsm #(.VW(VW)) u_ack (
        .clk(clk), .rst_n(rst_n), .ack_req(ack_req),
        .enable(spur_q[VW]), .pend_any(irr_any), .pend_top(irr_top),
        .pend_level(tmr_vec[irr_top]), .tpr(tpr_q), .spur_vec(spur_q[VW-1:0]),
        .take(take), .ack_valid(ack_valid), .ack_kind(ack_kind),
        .ack_vector(ack_vector), .ack_level(ack_level)
    );
endmodule

// File: rtl/vic_core_chk.sv
module vic_core_chk
    import vic_pkg::*;
#(
    parameter int NUM_VEC = 256,
    localparam int VW     = $clog2(NUM_VEC)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ack_req,
    input logic               eoi_strobe,
    input logic               irq_out,
    input logic [VW-1:0]      proc_pri,
    input logic               ack_valid,
    input logic [1:0]         ack_kind,
    input logic [VW-1:0]      ack_vector,
    input logic [VW-1:0]      tpr_q,
    input logic [VW:0]        spur_q,
    input logic [NUM_VEC-1:0] irr_vec,
    input logic [NUM_VEC-1:0] isr_vec
);
    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_quiet_chk: assert (!irq_out && proc_pri == '0 && !ack_valid);
        end
    end

    // R3
    pri_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        proc_pri >= tpr_q);

    // R4
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (spur_q[VW] && irr_vec != '0));

    // R5
    grant_in_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_kind == ACK_VEC) |-> isr_vec[ack_vector]);

    // R6
    spur_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_kind == ACK_SPUR) |-> ack_vector == $past(spur_q[VW-1:0]));

    // R8
    eoi_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_strobe && !ack_req && isr_vec != '0) |=>
            ($countones(isr_vec) == $past($countones(isr_vec)) - 1));

    // R10
    reply_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req |=> ack_valid);

    // R10
    no_stray_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_req |=> !ack_valid);

    // R10
    kind_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> ack_kind != 2'b11);
endmodule

bind vic_core vic_core_chk #(.NUM_VEC(NUM_VEC)) u_chk (
    .clk(clk), .rst_n(rst_n), .ack_req(ack_req), .eoi_strobe(eoi_strobe),
    .irq_out(irq_out), .proc_pri(proc_pri), .ack_valid(ack_valid),
    .ack_kind(ack_kind), .ack_vector(ack_vector), .tpr_q(tpr_q),
    .spur_q(spur_q), .irr_vec(irr_vec), .isr_vec(isr_vec)
);

// File: tb/vic_core_tb.sv
module vic_core_tb;
    localparam int VW = 8;
    localparam logic [1:0] K_NONE = 2'b00, K_VEC = 2'b01, K_SPUR = 2'b10;
    localparam logic [1:0] OP_SET = 2'd0, OP_ACK = 2'd1, OP_EOI = 2'd2;

    typedef struct packed {
        logic [1:0] op;
        logic [7:0] vec;
        logic       lvl;
        logic       irq;
        logic [7:0] ppr;
        logic [1:0] kind;
        logic [7:0] avec;
        logic       alvl;
    } row_t;

    localparam row_t TBL [0:9] = '{
        '{OP_SET, 8'h31, 1'b0, 1'b1, 8'h00, K_NONE, 8'h00, 1'b0},
        '{OP_SET, 8'h52, 1'b1, 1'b1, 8'h00, K_NONE, 8'h00, 1'b0},
        '{OP_ACK, 8'h00, 1'b0, 1'b0, 8'h50, K_VEC,  8'h52, 1'b1},
        '{OP_SET, 8'h67, 1'b0, 1'b1, 8'h50, K_NONE, 8'h00, 1'b0},
        '{OP_ACK, 8'h00, 1'b0, 1'b0, 8'h60, K_VEC,  8'h67, 1'b0},
        '{OP_EOI, 8'h00, 1'b0, 1'b0, 8'h50, K_NONE, 8'h00, 1'b0},
        '{OP_EOI, 8'h00, 1'b0, 1'b1, 8'h00, K_NONE, 8'h00, 1'b0},
        '{OP_ACK, 8'h00, 1'b0, 1'b0, 8'h30, K_VEC,  8'h31, 1'b0},
        '{OP_EOI, 8'h00, 1'b0, 1'b0, 8'h00, K_NONE, 8'h00, 1'b0},
        '{OP_ACK, 8'h00, 1'b0, 1'b0, 8'h00, K_NONE, 8'h00, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n;
    logic set_valid, set_level, tpr_wr, spur_wr, ack_req, eoi_strobe;
    logic [VW-1:0] set_vector, tpr_data;
    logic [VW:0] spur_data;
    logic irq_out, ack_valid, ack_level;
    logic [VW-1:0] proc_pri, ack_vector;
    logic [1:0] ack_kind;

    always #4 clk = ~clk;

    vic_core u_dut (
        .clk(clk), .rst_n(rst_n), .set_valid(set_valid), .set_vector(set_vector),
        .set_level(set_level), .tpr_wr(tpr_wr), .tpr_data(tpr_data),
        .spur_wr(spur_wr), .spur_data(spur_data), .ack_req(ack_req),
        .eoi_strobe(eoi_strobe), .irq_out(irq_out), .proc_pri(proc_pri),
        .ack_valid(ack_valid), .ack_kind(ack_kind), .ack_vector(ack_vector),
        .ack_level(ack_level)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        set_valid = 1'b0; ack_req = 1'b0; eoi_strobe = 1'b0;
        tpr_wr = 1'b0; spur_wr = 1'b0;
    endtask

    task automatic op_set(input logic [7:0] v, input logic l);
        set_valid = 1'b1; set_vector = v; set_level = l; step();
    endtask
    task automatic op_ack(); ack_req = 1'b1; step(); endtask
    task automatic op_eoi(); eoi_strobe = 1'b1; step(); endtask
    task automatic op_tpr(input logic [7:0] d); tpr_wr = 1'b1; tpr_data = d; step(); endtask
    task automatic op_spur(input logic [8:0] d); spur_wr = 1'b1; spur_data = d; step(); endtask

    task automatic obs(input string tag, input int irq, input int ppr);
        chk({tag, " irq_out"}, irq_out, irq);
        chk({tag, " proc_pri"}, proc_pri, ppr);
    endtask

    task automatic ack_exp(input string tag, input int kind, input int vec, input int lvl);
        chk({tag, " ack_valid"}, ack_valid, 1);
        chk({tag, " ack_kind"}, ack_kind, kind);
        if (kind != K_NONE) chk({tag, " ack_vector"}, ack_vector, vec);
        if (kind == K_VEC)  chk({tag, " ack_level"}, ack_level, lvl);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog R10 actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        set_valid = 1'b0; set_vector = '0; set_level = 1'b0;
        tpr_wr = 1'b0; tpr_data = '0; spur_wr = 1'b0; spur_data = '0;
        ack_req = 1'b0; eoi_strobe = 1'b0;
        repeat (3) @(negedge clk);
        obs("R1 in reset", 0, 0);
        chk("R1 in reset ack_valid", ack_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        obs("R1 after reset", 0, 0);

        // disabled at reset: request is held but neither signalled nor granted
        op_set(8'h40, 1'b0);
        obs("R4 disabled", 0, 0);
        op_ack();
        ack_exp("R7 disabled", K_NONE, 0, 0);
        op_spur(9'h1FF);
        obs("R4 enabled", 1, 0);
        op_ack();
        ack_exp("R5 first grant", K_VEC, 8'h40, 0);
        obs("R3 after grant", 0, 8'h40);
        op_eoi();
        obs("R8 retire", 0, 0);

        // table walk: nesting, class blocking, eoi order, empty acknowledge
        for (int i = 0; i < 10; i++) begin
            string tag;
            tag = $sformatf("R5/R8 row%0d", i);
            case (TBL[i].op)
                OP_SET:  op_set(TBL[i].vec, TBL[i].lvl);
                OP_ACK:  op_ack();
                default: op_eoi();
            endcase
            obs(tag, TBL[i].irq, TBL[i].ppr);
            if (TBL[i].op == OP_ACK) ack_exp(tag, TBL[i].kind, TBL[i].avec, TBL[i].alvl);
            else chk({tag, " R10 no reply"}, ack_valid, 0);
        end

        // task priority blocks: spurious reply leaves the request pending
        op_spur(9'h1F0);
        op_tpr(8'h45);
        op_set(8'h45, 1'b0);
        obs("R4 tpr block", 0, 8'h45);
        op_ack();
        ack_exp("R6 spurious", K_SPUR, 8'hF0, 0);
        obs("R6 state kept", 0, 8'h45);
        op_tpr(8'h00);
        obs("R6 still pending", 1, 0);
        op_ack();
        ack_exp("R6 later grant", K_VEC, 8'h45, 0);
        op_eoi();

        // same class as tpr: line stays low, acknowledge still grants
        op_tpr(8'h40);
        op_set(8'h4F, 1'b0);
        obs("R4 equal class", 0, 8'h40);
        op_ack();
        ack_exp("R6 above tpr", K_VEC, 8'h4F, 0);
        obs("R3 equal class", 0, 8'h40);
        op_tpr(8'h20);
        obs("R3 isr class wins", 0, 8'h40);
        op_eoi();
        obs("R3 tpr wins", 0, 8'h20);
        op_tpr(8'h00);

        // set and acknowledge of the same vector in one cycle
        op_set(8'h80, 1'b0);
        obs("R9 pre", 1, 0);
        set_valid = 1'b1; set_vector = 8'h80; set_level = 1'b0; ack_req = 1'b1;
        step();
        ack_exp("R9 collide", K_VEC, 8'h80, 0);
        obs("R9 repended", 0, 8'h80);
        op_eoi();
        obs("R9 after eoi", 1, 0);
        op_ack();
        ack_exp("R9 second grant", K_VEC, 8'h80, 0);
        op_eoi();

        // vector boundaries and trigger mode overwrite
        op_set(8'h00, 1'b0);
        obs("R4 vector0", 1, 0);
        op_ack();
        ack_exp("R5 vector0", K_VEC, 8'h00, 0);
        obs("R3 vector0", 0, 0);
        op_eoi();
        op_set(8'hFF, 1'b1);
        op_ack();
        ack_exp("R2 vector255 level", K_VEC, 8'hFF, 1);
        obs("R3 vector255", 0, 8'hF0);
        op_eoi();
        op_set(8'hFF, 1'b0);
        op_ack();
        ack_exp("R2 mode overwrite", K_VEC, 8'hFF, 0);
        op_eoi();

        // eoi with nothing in service
        op_eoi();
        obs("R8 empty eoi", 0, 0);
        chk("R10 empty eoi ack_valid", ack_valid, 0);

        // disabling with a request pending
        op_set(8'h90, 1'b0);
        obs("R4 pending", 1, 0);
        op_spur(9'h0F0);
        obs("R4 disabled again", 0, 0);
        op_ack();
        ack_exp("R7 disabled again", K_NONE, 0, 0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule